// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Guard

This block keeps the eight-bit status byte of a serial NOR flash. It decides, one clock after each decoded command strobe, whether a write-type command may run. The command decoder in front of it delivers one strobe per command: write enable, write disable, status write, page program, sector erase, block erase or chip erase. Along with the strobe come the target address and, for a status write, the new byte. Each command is answered with a single-cycle accept or reject pulse. An accepted program, erase or status write also raises a start pulse with an operation code toward the array sequencer, and sets the busy flag until the sequencer returns its done pulse.

Every write-type command is checked against three things: the write-enable latch, the protected region selected by the four protect-level bits, and the hardware lock formed by the register-lock bit, the pin-override bit and the write-protect pin. The six upper status bits stand in for non-volatile storage. A register-file reset clears them, but a modelled power cycle leaves them intact and clears only the volatile latch and busy flag. When one-time-programmable mode is selected, the register-lock bit also serves as the lock flag for the OTP sector.

Top module: `sflash_guard`

## Requirements
- R1: The status byte reads, from bit 7 down: register-lock, pin-override, protect level (bits 5..2, bit 5 most significant), write-enable latch (bit 1), busy (bit 0). After reset it reads 0x00, and accept, reject and start are low.
- R2: When not busy, write enable is accepted and sets bit 1. Write disable is accepted and clears bit 1. Neither raises start.
- R3: With bit 1 at 0, status write, program, sector erase, block erase and chip erase give a reject pulse one cycle after the strobe, no start, and no change to the status byte.
- R4: An accepted write-type command gives accept and start one cycle after its strobe, with seq_op 1 = status write, 2 = page program, 3 = sector erase, 4 = block erase, 5 = chip erase. Busy reads 1 from that cycle on.
- R5: A done pulse while busy clears busy and bit 1 on the next cycle. For a status write, bits 7..2 take bits 7..2 of the byte given with the command. A done pulse while idle has no effect.
- R6: With address bits 18..16 as the 64 KB block number, protect level n from 1 to 7 covers the top 2^(n-1) blocks, and a level of 8 or more covers all of them. Program, sector erase or block erase into a covered block is rejected, and bit 1 is left unchanged.
- R7: Chip erase is accepted only when the protect level is 0. Otherwise it is rejected.
- R8: When bit 7 is 1, bit 6 is 0 and wp_n is low, a status write is rejected.
- R9: While busy, including the cycle in which done arrives, every command strobe is ignored: no accept, no reject, no state change.
- R10: A pwr_cycle pulse clears bits 1 and 0 and drops any pending status write. Bits 7..2 are kept. Commands in that cycle are ignored.
- R11: otp_lock is high exactly when otp_mode is high and bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_cycle | input | 1 | Modelled power-cycle pulse |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_pp | input | 1 | Page-program strobe |
| cmd_se | input | 1 | Sector-erase strobe |
| cmd_be | input | 1 | Block-erase strobe |
| cmd_ce | input | 1 | Chip-erase strobe |
| wr_byte | input | 8 | Byte for status write |
| addr | input | ADDR_W | Target address |
| wp_n | input | 1 | Write-protect pin, active low |
| otp_mode | input | 1 | OTP mode select |
| seq_done | input | 1 | Sequencer completion pulse |
| status | output | 8 | Status byte |
| otp_lock | output | 1 | OTP sector locked |
| cmd_accept | output | 1 | Command accepted pulse |
| cmd_reject | output | 1 | Command rejected pulse |
| seq_start | output | 1 | Sequencer start pulse |
| seq_op | output | 3 | Operation code for sequencer |

## Verification
A sequencer done pulse and a new command strobe can land in the same cycle, so two actions compete there: finishing the running operation and accepting new work. The bench raises seq_done and a write-enable strobe on the same clock edge while a block erase is running. It then requires three things: no accept or reject pulse, busy and the latch both reading 0 afterwards, and an empty scoreboard queue. Together these show the late strobe was dropped rather than applied after completion.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_WRSR = 3'd1,
    OP_PP   = 3'd2,
    OP_SE   = 3'd3,
    OP_BE   = 3'd4,
    OP_CE   = 3'd5
  } op_e;

  localparam int ST_W = 8;
  localparam int NV_W = 6;
  localparam int BP_W = 4;
endpackage

// File: rtl/sfg_region.sv
module sfg_region #(
  parameter int ADDR_W = 19,
  parameter int BLK_AW = 16,
  parameter int BP_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BP_W-1:0]   level,
  output logic              hit
);
  localparam int BLK_IDX_W = ADDR_W - BLK_AW;
  localparam int NUM_BLK   = 1 << BLK_IDX_W;
  localparam int NUM_LVL   = 1 << BP_W;

  logic [BLK_IDX_W-1:0] blk;
  logic [NUM_LVL-1:0]   hit_vec;
  logic                 unused_low;

  assign blk        = addr[ADDR_W-1:BLK_AW];
  assign unused_low = ^addr[BLK_AW-1:0];

  // one comparator per protect level; level 0 protects nothing
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    localparam int SH      = (i == 0) ? 0 : i - 1;
    localparam bit COVERS  = (i != 0) && (SH >= BLK_IDX_W);
    localparam int FIRST   = (i == 0) ? NUM_BLK :
                             (COVERS ? 0 : NUM_BLK - (1 << SH));
    if (i == 0) begin : g_none
      assign hit_vec[i] = 1'b0;
    end else begin : g_cmp
      assign hit_vec[i] = (32'(blk) >= 32'(FIRST));
    end
  end

  assign hit = hit_vec[level];
endmodule

// File: rtl/sfg_gate.sv
module sfg_gate
  import sfg_pkg::*;
#(
  parameter int BP_W = 4
) (
  input  logic            wren,
  input  logic            wrdi,
  input  logic            wrsr,
  input  logic            pp,
  input  logic            se,
  input  logic            be,
  input  logic            ce,
  input  logic            busy,
  input  logic            wel,
  input  logic [BP_W-1:0] level,
  input  logic            hw_lock,
  input  logic            in_region,
  output logic            acc,
  output logic            rej,
  output op_e             op,
  output logic            wel_set,
  output logic            wel_clr,
  output logic            start,
  output logic            wrsr_go
);
  logic any_wr;
  logic allowed;

  assign any_wr = wrsr | pp | se | be | ce;

  always_comb begin
    allowed = 1'b0;
    op      = OP_NONE;
    if (wrsr) begin
      allowed = wel & ~hw_lock;
      op      = OP_WRSR;
    end else if (pp | se | be) begin
      allowed = wel & ~in_region;
      op      = pp ? OP_PP : (se ? OP_SE : OP_BE);
    end else if (ce) begin
      allowed = wel & (level == '0);
      op      = OP_CE;
    end
    if (busy || !allowed) op = OP_NONE;
  end

  assign acc     = ~busy & (wren | wrdi | (any_wr & allowed));
  assign rej     = ~busy & any_wr & ~allowed;
  assign wel_set = ~busy & wren;
  assign wel_clr = ~busy & wrdi;
  assign start   = ~busy & any_wr & allowed;
  assign wrsr_go = ~busy & wrsr & allowed;
endmodule

// File: rtl/sfg_status.sv
module sfg_status
  import sfg_pkg::*;
#(
  parameter logic [NV_W-1:0] NV_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr,
  input  logic            seq_done,
  input  logic            wel_set,
  input  logic            wel_clr,
  input  logic            start,
  input  logic            wrsr_go,
  input  logic [ST_W-1:0] wr_byte,
  output logic [ST_W-1:0] status
);
  logic [NV_W-1:0] nv_q, pend_q;
  logic            wel_q, wel_d;
  logic            wip_q, wip_d;
  logic            pv_q, pv_d;
  logic            nv_ld, pend_ld, finish;
  logic            unused_lsb;

  assign unused_lsb = ^wr_byte[1:0];
  assign finish     = wip_q & seq_done;

  always_comb begin
    wel_d   = wel_q;
    wip_d   = wip_q;
    pv_d    = pv_q;
    nv_ld   = 1'b0;
    pend_ld = 1'b0;
    if (pwr) begin
      wel_d = 1'b0;
      wip_d = 1'b0;
      pv_d  = 1'b0;
    end else if (finish) begin
      wel_d = 1'b0;
      wip_d = 1'b0;
      pv_d  = 1'b0;
      nv_ld = pv_q;
    end else begin
      if (wel_set) wel_d = 1'b1;
      if (wel_clr) wel_d = 1'b0;
      if (start)   wip_d = 1'b1;
      if (wrsr_go) begin
        pend_ld = 1'b1;
        pv_d    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q   <= NV_RESET;
      pend_q <= '0;
      wel_q  <= 1'b0;
      wip_q  <= 1'b0;
      pv_q   <= 1'b0;
    end else begin
      wel_q <= wel_d;
      wip_q <= wip_d;
      pv_q  <= pv_d;
      if (nv_ld)   nv_q   <= pend_q;
      if (pend_ld) pend_q <= wr_byte[ST_W-1:2];
    end
  end

  assign status = {nv_q, wel_q, wip_q};

  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_q && seq_done && !pwr) |=> (!wip_q && !wel_q));

  assert_pwr_keeps_nv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr |=> ($stable(nv_q) && !wip_q && !wel_q));
endmodule

// File: rtl/sflash_guard.sv
module sflash_guard
  import sfg_pkg::*;
#(
  parameter int              ADDR_W   = 19,
  parameter int              BLK_AW   = 16,
  parameter logic [NV_W-1:0] NV_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_cycle,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic              cmd_ce,
  input  logic [ST_W-1:0]   wr_byte,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_n,
  input  logic              otp_mode,
  input  logic              seq_done,
  output logic [ST_W-1:0]   status,
  output logic              otp_lock,
  output logic              cmd_accept,
  output logic              cmd_reject,
  output logic              seq_start,
  output logic [2:0]        seq_op
);
  logic [1:0]      rst_sync;
  logic            rst_ni;
  logic [ST_W-1:0] st;
  logic [BP_W-1:0] level;
  logic            lock_bit, pin_ovr, wel, wip, hw_lock, in_region;
  logic            g_acc, g_rej, g_wel_set, g_wel_clr, g_start, g_wrsr_go;
  op_e             g_op;
  logic            acc_q, acc_d, rej_q, rej_d, start_q, start_d;
  op_e             op_q, op_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign lock_bit = st[7];
  assign pin_ovr  = st[6];
  assign level    = st[5:2];
  assign wel      = st[1];
  assign wip      = st[0];
  assign hw_lock  = lock_bit & ~pin_ovr & ~wp_n;

  sfg_region #(.ADDR_W(ADDR_W), .BLK_AW(BLK_AW), .BP_W(BP_W)) u_region (
    .addr  (addr),
    .level (level),
    .hit   (in_region)
  );

  sfg_gate #(.BP_W(BP_W)) u_gate (
    .wren      (cmd_wren),
    .wrdi      (cmd_wrdi),
    .wrsr      (cmd_wrsr),
    .pp        (cmd_pp),
    .se        (cmd_se),
    .be        (cmd_be),
    .ce        (cmd_ce),
    .busy      (wip | pwr_cycle),
    .wel       (wel),
    .level     (level),
    .hw_lock   (hw_lock),
    .in_region (in_region),
    .acc       (g_acc),
    .rej       (g_rej),
    .op        (g_op),
    .wel_set   (g_wel_set),
    .wel_clr   (g_wel_clr),
    .start     (g_start),
    .wrsr_go   (g_wrsr_go)
  );

  sfg_status #(.NV_RESET(NV_RESET)) u_status (
    .clk      (clk),
    .rst_n    (rst_ni),
    .pwr      (pwr_cycle),
    .seq_done (seq_done),
    .wel_set  (g_wel_set),
    .wel_clr  (g_wel_clr),
    .start    (g_start),
    .wrsr_go  (g_wrsr_go),
    .wr_byte  (wr_byte),
    .status   (st)
  );

  always_comb begin
    acc_d   = g_acc;
    rej_d   = g_rej;
    start_d = g_start;
    op_d    = g_start ? g_op : OP_NONE;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= 1'b0;
      rej_q   <= 1'b0;
      start_q <= 1'b0;
      op_q    <= OP_NONE;
    end else begin
      acc_q   <= acc_d;
      rej_q   <= rej_d;
      start_q <= start_d;
      op_q    <= op_d;
    end
  end

  assign status     = st;
  assign otp_lock   = otp_mode & lock_bit;
  assign cmd_accept = acc_q;
  assign cmd_reject = rej_q;
  assign seq_start  = start_q;
  assign seq_op     = op_q;

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    wip |=> !(cmd_accept || cmd_reject));

  assert_reject_keeps_wel_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_reject |-> ($stable(st[1]) && !seq_start));

  assert_start_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    seq_start |-> (wip && cmd_accept));

  assert_ce_needs_level0_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (seq_start && op_q == OP_CE) |-> ($past(level) == '0));
endmodule

// File: tb/sflash_guard_test.sv
module sflash_guard_test;
  localparam int ADDR_W = 19;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, pwr_cycle, cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be, cmd_ce;
  logic [7:0] wr_byte;
  logic [ADDR_W-1:0] addr;
  logic wp_n, otp_mode, seq_done;
  logic [7:0] status;
  logic otp_lock, cmd_accept, cmd_reject, seq_start;
  logic [2:0] seq_op;

  sflash_guard #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be), .cmd_ce(cmd_ce),
    .wr_byte(wr_byte), .addr(addr), .wp_n(wp_n), .otp_mode(otp_mode),
    .seq_done(seq_done), .status(status), .otp_lock(otp_lock),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
    .seq_start(seq_start), .seq_op(seq_op)
  );

  typedef struct {
    bit       acc;
    bit       rej;
    bit [2:0] op;
    string    req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   run = 0;
  bit   ended = 0;

  // bench model of the status byte
  logic [5:0] m_nv, m_pend;
  logic       m_wel, m_wip, m_pv;

  localparam int K_WREN = 0, K_WRDI = 1, K_WRSR = 2, K_PP = 3, K_SE = 4, K_BE = 5, K_CE = 6;

  task automatic note(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic bit m_prot(logic [ADDR_W-1:0] a);
    logic [3:0] lv;
    int blk;
    lv  = m_nv[3:0];
    blk = int'(a[18:16]);
    if (lv == 0) return 1'b0;
    if (lv >= 4) return 1'b1;
    return blk >= (8 - (1 << (lv - 1)));
  endfunction

  task automatic chk_status(string req);
    note(status == {m_nv, m_wel, m_wip}, req, "status", 32'(status), 32'({m_nv, m_wel, m_wip}));
  endtask

  task automatic clear_strobes();
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_pp = 0; cmd_se = 0; cmd_be = 0; cmd_ce = 0;
  endtask

  task automatic cmd(int k, logic [ADDR_W-1:0] a, logic [7:0] d, string req);
    bit ok;
    exp_t e;
    @(negedge clk);
    addr = a;
    wr_byte = d;
    case (k)
      K_WREN: cmd_wren = 1;
      K_WRDI: cmd_wrdi = 1;
      K_WRSR: cmd_wrsr = 1;
      K_PP:   cmd_pp = 1;
      K_SE:   cmd_se = 1;
      K_BE:   cmd_be = 1;
      default: cmd_ce = 1;
    endcase
    if (!m_wip) begin
      case (k)
        K_WREN, K_WRDI: ok = 1;
        K_WRSR: ok = m_wel && !(m_nv[5] && !m_nv[4] && !wp_n);
        K_PP, K_SE, K_BE: ok = m_wel && !m_prot(a);
        default: ok = m_wel && (m_nv[3:0] == 0);
      endcase
      e.acc = ok;
      e.rej = !ok;
      e.op  = (ok && k >= K_WRSR) ? 3'(k - 1) : 3'd0;
      e.req = req;
      exp_q.push_back(e);
      if (ok) begin
        if (k == K_WREN) m_wel = 1;
        if (k == K_WRDI) m_wel = 0;
        if (k >= K_WRSR) m_wip = 1;
        if (k == K_WRSR) begin m_pend = d[7:2]; m_pv = 1; end
      end
    end
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic finish_op(bit plus_wren);
    @(negedge clk);
    seq_done = 1;
    cmd_wren = plus_wren;
    if (m_wip) begin
      m_wip = 0;
      m_wel = 0;
      if (m_pv) m_nv = m_pend;
      m_pv = 0;
    end
    @(negedge clk);
    seq_done = 0;
    cmd_wren = 0;
  endtask

  task automatic power_cycle();
    @(negedge clk);
    pwr_cycle = 1;
    m_wel = 0; m_wip = 0; m_pv = 0;
    @(negedge clk);
    pwr_cycle = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (run && (cmd_accept || cmd_reject || seq_start)) begin
      if (exp_q.size() == 0) begin
        note(0, "R9", "unexpected response", {29'd0, cmd_accept, cmd_reject, seq_start}, 0);
      end else begin
        e = exp_q.pop_front();
        note({cmd_accept, cmd_reject} == {e.acc, e.rej}, e.req, "accept/reject",
             {30'd0, cmd_accept, cmd_reject}, {30'd0, e.acc, e.rej});
        note(seq_start == (e.op != 0), e.req, "start", 32'(seq_start), 32'(e.op != 0));
        note(seq_op == e.op, e.req, "seq_op", 32'(seq_op), 32'(e.op));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pwr_cycle = 0; seq_done = 0; wp_n = 1; otp_mode = 0;
    wr_byte = 0; addr = 0;
    clear_strobes();
    m_nv = 0; m_pend = 0; m_wel = 0; m_wip = 0; m_pv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_status("R1");
    note(!cmd_accept && !cmd_reject && !seq_start, "R1", "outputs idle",
         {29'd0, cmd_accept, cmd_reject, seq_start}, 0);
    run = 1;

    // R3 program without latch
    cmd(K_PP, 19'h00000, 8'h00, "R3");
    chk_status("R3");

    // R2 latch set and clear
    cmd(K_WREN, 0, 0, "R2");
    chk_status("R2");
    cmd(K_WRDI, 0, 0, "R2");
    chk_status("R2");

    // R4 status write, busy ignores, R5 completion
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_WRSR, 0, 8'h0C, "R4");
    note(status[0] == 1'b1, "R4", "busy", 32'(status[0]), 1);
    cmd(K_PP, 19'h00000, 0, "R9");
    note(!cmd_accept && !cmd_reject, "R9", "ignored while busy",
         {30'd0, cmd_accept, cmd_reject}, 0);
    chk_status("R9");
    finish_op(0);
    chk_status("R5");

    // R6 level 3 covers top four blocks
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_PP, 19'h40000, 0, "R6");
    chk_status("R6");
    cmd(K_PP, 19'h3FFFF, 0, "R6");
    finish_op(0);

    // R7 chip erase with nonzero level
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_CE, 0, 0, "R7");
    chk_status("R7");
    cmd(K_SE, 19'h10000, 0, "R4");
    finish_op(0);

    // R9 done and strobe in the same cycle
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_BE, 19'h00000, 0, "R4");
    finish_op(1);
    chk_status("R9");

    // R6 level 1 covers only the top block
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_WRSR, 0, 8'h04, "R4");
    finish_op(0);
    chk_status("R5");
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_PP, 19'h70000, 0, "R6");
    cmd(K_PP, 19'h6FFFF, 0, "R6");
    finish_op(0);

    // R6 level 8 covers everything
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_WRSR, 0, 8'h20, "R4");
    finish_op(0);
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_PP, 19'h00000, 0, "R6");
    chk_status("R6");
    cmd(K_WRSR, 0, 8'hA0, "R4");
    finish_op(0);
    chk_status("R5");

    // R11 OTP lock flag
    @(negedge clk);
    otp_mode = 1;
    @(negedge clk);
    note(otp_lock == 1'b1, "R11", "otp_lock", 32'(otp_lock), 1);
    otp_mode = 0;
    @(negedge clk);
    note(otp_lock == 1'b0, "R11", "otp_lock", 32'(otp_lock), 0);

    // R8 hardware lock
    wp_n = 0;
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_WRSR, 0, 8'h00, "R8");
    chk_status("R8");
    wp_n = 1;
    cmd(K_WRSR, 0, 8'h00, "R8");
    finish_op(0);
    chk_status("R8");

    // R7 chip erase with level 0
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_CE, 0, 0, "R7");
    finish_op(0);
    chk_status("R7");

    // R10 power cycle
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_WRSR, 0, 8'h14, "R4");
    finish_op(0);
    cmd(K_WREN, 0, 0, "R2");
    power_cycle();
    chk_status("R10");
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_WRSR, 0, 8'h00, "R4");
    power_cycle();
    chk_status("R10");
    finish_op(0);
    chk_status("R5");

    repeat (2) @(negedge clk);
    note(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule